// File: doc/BRIEF.md
# Multi-Channel Frame Offset Timing Generator

This block keeps the downlink timing reference of a base station in one place. A chip counter runs over a 38400-chip reference frame and carries a 12-bit frame number. Every other timing grid is decoded from that single counter: frame-start strobes for several derived channels, each shifted by its own offset in units of 256 chips, a paging-indicator strobe that runs a fixed distance ahead of its paired channel, a random-access slot grid that spans two frames, a shared-control subframe grid, the delayed data subframe that follows it, and a fixed-offset control-channel frame.

The counter moves only on cycles where `chip_en` is high. Every strobe is a single-cycle pulse in the cycle after the enabling edge, so one strobe stands for one chip. Software writes new channel offsets onto `cfg_offset` and pulses `cfg_load`. A two-state controller holds the captured values until the next reference frame boundary. State `CFG_RUN` is the steady state. The transition *capture* (`cfg_load` high) moves it to `CFG_ARMED`. In `CFG_ARMED`, a later `cfg_load` is the transition *recapture* and keeps the state. The transition *apply* (an enabled tick on the last chip of a frame, with no load) copies the captured offsets into the active set and returns to `CFG_RUN`. If a load and a frame boundary fall on the same edge while armed, the older captured values are applied and the new ones wait for the following boundary.

Top module: `frame_offset_timer`

## Requirements
- R1: While reset is held, all strobes are low, `chip_pos` reads 38399, `frame_num` reads 4095, `slot_num` reads 14 and `sub_num` reads 4. The first enabled tick after reset opens chip 0 of frame 0 and raises `frame_start`.
- R2: `chip_pos` advances by one only on an enabled tick and wraps from 38399 to 0. On that wrap `frame_num` increments modulo 4096. When `chip_en` is low, `chip_pos` and `frame_num` hold.
- R3: Channel c (`chan_start[c]`, with c taken from the bit index) strobes once per frame, at chip offset×256 of its active offset. Channel c's offset is the byte `cfg_offset[8c+7:8c]`.
- R4: A programmed offset above 149 is taken as 149.
- R5: Channel 0 is the broadcast-carrying channel. Its offset is always 0, whatever value is programmed, so `chan_start[0]` coincides with `frame_start`.
- R6: New offsets take effect at the first frame boundary that follows the `cfg_load` edge. Until then every channel keeps its previous grid.
- R7: `page_start` fires 7680 chips before the frame start of channel 1. It sits at chip (offset×256 + 30720) mod 38400, which places it in the previous frame when channel 1's offset is below 30.
- R8: `slot_start` fires every 5120 chips. `slot_num` counts 0 to 14 over two frames, and slot 0 begins at the start of every even-numbered frame.
- R9: `sub_start` fires every 7680 chips, aligned with the frame start. `sub_num` counts 0 to 4 within each frame.
- R10: `data_start` fires 5120 chips after each `sub_start`.
- R11: `ctrl_start` fires once per frame, at chip 5120.
- R12: Every strobe lasts one cycle and is raised only in the cycle that follows an edge where `chip_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip tick enable; one high edge is one chip |
| cfg_load | input | 1 | Single-cycle pulse that captures `cfg_offset` |
| cfg_offset | input | 32 | Four 8-bit channel offsets in 256-chip units, channel c in bits 8c+7:8c |
| chip_pos | output | 16 | Chip index within the reference frame |
| frame_num | output | 12 | Reference frame number |
| frame_start | output | 1 | Reference frame start strobe |
| chan_start | output | 4 | Per-channel frame start strobes |
| page_start | output | 1 | Paging-indicator frame start strobe, leading channel 1 |
| ctrl_start | output | 1 | Fixed-offset control-channel frame start strobe |
| slot_start | output | 1 | Access-slot start strobe |
| slot_num | output | 4 | Access-slot index, 0 to 14 |
| sub_start | output | 1 | Shared-control subframe start strobe |
| sub_num | output | 3 | Subframe index, 0 to 4 |
| data_start | output | 1 | Delayed data-subframe start strobe |

## Verification
The assertions assume three things about the inputs. Reset is asserted from time zero for at least one clock edge. `chip_en` holds a known value on every edge, including the edges during reset, because the strobe-gating and counter-hold properties look one cycle back at it. Offsets only need to be known at the `cfg_load` edge, since the clamp property checks the active registers and not the raw inputs. The stimulus drives every input to a defined level before reset is released and changes inputs only half a period away from the sampling edge. It issues each load as a one-cycle pulse that lands away from a frame boundary, so the rule that the older captured values win when a load and a boundary coincide is never exercised.

// File: rtl/ftg_pkg.sv
`timescale 1ns/1ps
package ftg_pkg;

    // Offset reconfiguration controller states
    typedef enum logic [0:0] {
        CFG_RUN   = 1'b0,   // active offsets in use, nothing pending
        CFG_ARMED = 1'b1    // captured offsets wait for the next frame boundary
    } cfg_state_e;

endpackage

// File: rtl/ftg_ref_counter.sv
`timescale 1ns/1ps
// Reference chip counter with frame number; parked on the last chip of
// the last frame during reset so that the first tick opens frame 0.
module ftg_ref_counter #(
    parameter int FRAME_LEN = 38400,
    parameter int CHIP_W    = 16,
    parameter int FN_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [CHIP_W-1:0] chip_q,
    output logic [FN_W-1:0]   fn_q,
    output logic              last_chip
);

    localparam logic [CHIP_W-1:0] LAST = CHIP_W'(FRAME_LEN - 1);

    assign last_chip = (chip_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_q <= LAST;
            fn_q   <= '1;
        end else if (tick) begin
            if (last_chip) begin
                chip_q <= '0;
                fn_q   <= fn_q + 1'b1;
            end else begin
                chip_q <= chip_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ftg_grid_counter.sv
`timescale 1ns/1ps
// Position/index counter for a repeating grid of PERIOD chips and COUNT
// cells; parked on the last chip of the last cell during reset.
module ftg_grid_counter #(
    parameter int PERIOD = 5120,
    parameter int COUNT  = 15,
    parameter int POS_W  = 13,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [POS_W-1:0] pos_q,
    output logic [IDX_W-1:0] idx_q
);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(PERIOD - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(COUNT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= POS_LAST;
            idx_q <= IDX_LAST;
        end else if (tick) begin
            if (pos_q == POS_LAST) begin
                pos_q <= '0;
                idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ftg_offset_ctrl.sv
`timescale 1ns/1ps
// Offset capture and frame-boundary apply controller.
module ftg_offset_ctrl
    import ftg_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int OFS_W     = 8,
    parameter int MAX_UNITS = 149,
    parameter int BCAST_CH  = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    last_chip,
    input  logic                    load,
    input  logic [NUM_CH*OFS_W-1:0] cfg_offset,
    output logic [NUM_CH*OFS_W-1:0] act_offset
);

    localparam logic [OFS_W-1:0] LIMIT = OFS_W'(MAX_UNITS);

    cfg_state_e              state_q, state_d;
    logic [NUM_CH*OFS_W-1:0] clamped;
    logic [NUM_CH*OFS_W-1:0] shadow_q;
    logic                    apply;

    // Per-channel range limit; the broadcast channel is pinned to zero
    for (genvar c = 0; c < NUM_CH; c++) begin : g_clamp
        if (c == BCAST_CH) begin : g_bcast
            assign clamped[c*OFS_W +: OFS_W] = '0;
        end else begin : g_limit
            assign clamped[c*OFS_W +: OFS_W] =
                (cfg_offset[c*OFS_W +: OFS_W] > LIMIT) ? LIMIT
                                                       : cfg_offset[c*OFS_W +: OFS_W];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_RUN;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        apply   = 1'b0;
        unique case (state_q)
            CFG_RUN: begin
                if (load) state_d = CFG_ARMED;          // capture
            end
            CFG_ARMED: begin
                apply = tick && last_chip;
                if (load)       state_d = CFG_ARMED;    // recapture
                else if (apply) state_d = CFG_RUN;      // apply
            end
            default: state_d = CFG_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q   <= '0;
            act_offset <= '0;
        end else begin
            if (apply) act_offset <= shadow_q;
            if (load)  shadow_q   <= clamped;
        end
    end

endmodule

// File: rtl/frame_offset_timer.sv
`timescale 1ns/1ps
// Multi-channel frame offset timing generator (top).
module frame_offset_timer #(
    parameter int FRAME_LEN   = 38400,
    parameter int UNIT_CHIPS  = 256,
    parameter int MAX_UNITS   = 149,
    parameter int NUM_CH      = 4,
    parameter int BCAST_CH    = 0,
    parameter int PAGE_CH     = 1,
    parameter int PAGE_LEAD   = 7680,
    parameter int SLOT_CHIPS  = 5120,
    parameter int SLOT_COUNT  = 15,
    parameter int SUB_CHIPS   = 7680,
    parameter int DATA_DELAY  = 5120,
    parameter int CTRL_OFS    = 5120,
    parameter int FN_W        = 12,
    localparam int CHIP_W     = $clog2(FRAME_LEN),
    localparam int OFS_W      = $clog2(MAX_UNITS + 1),
    localparam int SLOT_W     = $clog2(SLOT_COUNT),
    localparam int SUB_COUNT  = FRAME_LEN / SUB_CHIPS,
    localparam int SUB_W      = $clog2(SUB_COUNT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    chip_en,
    input  logic                    cfg_load,
    input  logic [NUM_CH*OFS_W-1:0] cfg_offset,
    output logic [CHIP_W-1:0]       chip_pos,
    output logic [FN_W-1:0]         frame_num,
    output logic                    frame_start,
    output logic [NUM_CH-1:0]       chan_start,
    output logic                    page_start,
    output logic                    ctrl_start,
    output logic                    slot_start,
    output logic [SLOT_W-1:0]       slot_num,
    output logic                    sub_start,
    output logic [SUB_W-1:0]        sub_num,
    output logic                    data_start
);

    localparam int SLOT_POS_W = $clog2(SLOT_CHIPS);
    localparam int SUB_POS_W  = $clog2(SUB_CHIPS);

    logic                    tick_q;
    logic                    last_chip;
    logic [SLOT_POS_W-1:0]   slot_pos;
    logic [SUB_POS_W-1:0]    sub_pos;
    logic [NUM_CH*OFS_W-1:0] act_offset;

    // Strobes qualify on the edge that moved the counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= chip_en;
    end

    ftg_ref_counter #(
        .FRAME_LEN (FRAME_LEN),
        .CHIP_W    (CHIP_W),
        .FN_W      (FN_W)
    ) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (chip_en),
        .chip_q    (chip_pos),
        .fn_q      (frame_num),
        .last_chip (last_chip)
    );

    // Access-slot grid spans two reference frames
    ftg_grid_counter #(
        .PERIOD (SLOT_CHIPS),
        .COUNT  (SLOT_COUNT),
        .POS_W  (SLOT_POS_W),
        .IDX_W  (SLOT_W)
    ) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (chip_en),
        .pos_q (slot_pos),
        .idx_q (slot_num)
    );

    ftg_grid_counter #(
        .PERIOD (SUB_CHIPS),
        .COUNT  (SUB_COUNT),
        .POS_W  (SUB_POS_W),
        .IDX_W  (SUB_W)
    ) u_sub (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (chip_en),
        .pos_q (sub_pos),
        .idx_q (sub_num)
    );

    ftg_offset_ctrl #(
        .NUM_CH    (NUM_CH),
        .OFS_W     (OFS_W),
        .MAX_UNITS (MAX_UNITS),
        .BCAST_CH  (BCAST_CH)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (chip_en),
        .last_chip  (last_chip),
        .load       (cfg_load),
        .cfg_offset (cfg_offset),
        .act_offset (act_offset)
    );

    assign frame_start = tick_q && (chip_pos == '0);
    assign ctrl_start  = tick_q && (chip_pos == CHIP_W'(CTRL_OFS));
    assign slot_start  = tick_q && (slot_pos == '0);
    assign sub_start   = tick_q && (sub_pos == '0);
    assign data_start  = tick_q && (sub_pos == SUB_POS_W'(DATA_DELAY));

    // Per-channel frame grids
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [OFS_W-1:0] units;
        logic [31:0]      start_chip;
        assign units         = act_offset[c*OFS_W +: OFS_W];
        assign start_chip    = 32'(units) * 32'(UNIT_CHIPS);
        assign chan_start[c] = tick_q && (32'(chip_pos) == start_chip);
    end

    // Paging grid leads its paired channel, wrapping modulo the frame
    logic [OFS_W-1:0] page_units;
    logic [31:0]      page_raw;
    logic [31:0]      page_chip;
    assign page_units = act_offset[PAGE_CH*OFS_W +: OFS_W];
    assign page_raw   = 32'(page_units) * 32'(UNIT_CHIPS) + 32'(FRAME_LEN - PAGE_LEAD);
    assign page_chip  = (page_raw >= 32'(FRAME_LEN)) ? page_raw - 32'(FRAME_LEN) : page_raw;
    assign page_start = tick_q && (32'(chip_pos) == page_chip);

endmodule

// File: rtl/ftg_checker.sv
`timescale 1ns/1ps
// Property checker attached to frame_offset_timer.
module ftg_checker #(
    parameter int FRAME_LEN  = 38400,
    parameter int MAX_UNITS  = 149,
    parameter int NUM_CH     = 4,
    parameter int BCAST_CH   = 0,
    parameter int SLOT_COUNT = 15,
    parameter int SUB_CHIPS  = 7680,
    parameter int FN_W       = 12,
    localparam int CHIP_W    = $clog2(FRAME_LEN),
    localparam int OFS_W     = $clog2(MAX_UNITS + 1),
    localparam int SLOT_W    = $clog2(SLOT_COUNT),
    localparam int SUB_COUNT = FRAME_LEN / SUB_CHIPS,
    localparam int SUB_W     = $clog2(SUB_COUNT)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    chip_en,
    input logic [CHIP_W-1:0]       chip_pos,
    input logic [FN_W-1:0]         frame_num,
    input logic                    frame_start,
    input logic [NUM_CH-1:0]       chan_start,
    input logic                    ctrl_start,
    input logic                    slot_start,
    input logic [SLOT_W-1:0]       slot_num,
    input logic                    sub_start,
    input logic [SUB_W-1:0]        sub_num,
    input logic                    data_start,
    input logic [NUM_CH*OFS_W-1:0] act_offset
);

    assert_chip_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chip_pos <= CHIP_W'(FRAME_LEN - 1));

    assert_chip_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(chip_en) |-> ($stable(chip_pos) && $stable(frame_num)));

    assert_frame_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chip_en) && ($past(chip_pos) == CHIP_W'(FRAME_LEN - 1)))
        |-> (frame_num == FN_W'($past(frame_num) + 1'b1)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ofs
        assert_offset_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
            act_offset[c*OFS_W +: OFS_W] <= OFS_W'(MAX_UNITS));
    end

    assert_bcast_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start[BCAST_CH] |-> frame_start);

    assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_num <= SLOT_W'(SLOT_COUNT - 1));

    assert_slot_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !frame_num[0]) |-> (slot_start && slot_num == '0));

    assert_sub_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (sub_start && sub_num == '0));

    assert_sub_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sub_num <= SUB_W'(SUB_COUNT - 1));

    assert_ctrl_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_start |-> (data_start && sub_num == '0));

    assert_tick_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start || (|chan_start) || ctrl_start || slot_start || sub_start || data_start)
        |-> $past(chip_en));

endmodule

bind frame_offset_timer ftg_checker #(
    .FRAME_LEN  (FRAME_LEN),
    .MAX_UNITS  (MAX_UNITS),
    .NUM_CH     (NUM_CH),
    .BCAST_CH   (BCAST_CH),
    .SLOT_COUNT (SLOT_COUNT),
    .SUB_CHIPS  (SUB_CHIPS),
    .FN_W       (FN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en     (chip_en),
    .chip_pos    (chip_pos),
    .frame_num   (frame_num),
    .frame_start (frame_start),
    .chan_start  (chan_start),
    .ctrl_start  (ctrl_start),
    .slot_start  (slot_start),
    .slot_num    (slot_num),
    .sub_start   (sub_start),
    .sub_num     (sub_num),
    .data_start  (data_start),
    .act_offset  (act_offset)
);

// File: tb/tb_frame_offset_timer.sv
`timescale 1ns/1ps
module tb_frame_offset_timer;

    localparam int LAST = 38399;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        chip_en;
    logic        cfg_load;
    logic [31:0] cfg_offset;
    logic [15:0] chip_pos;
    logic [11:0] frame_num;
    logic        frame_start;
    logic [3:0]  chan_start;
    logic        page_start;
    logic        ctrl_start;
    logic        slot_start;
    logic [3:0]  slot_num;
    logic        sub_start;
    logic [2:0]  sub_num;
    logic        data_start;

    always #2.5 clk = ~clk;

    frame_offset_timer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chip_en     (chip_en),
        .cfg_load    (cfg_load),
        .cfg_offset  (cfg_offset),
        .chip_pos    (chip_pos),
        .frame_num   (frame_num),
        .frame_start (frame_start),
        .chan_start  (chan_start),
        .page_start  (page_start),
        .ctrl_start  (ctrl_start),
        .slot_start  (slot_start),
        .slot_num    (slot_num),
        .sub_start   (sub_start),
        .sub_num     (sub_num),
        .data_start  (data_start)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Input values as the design saw them on each edge
    logic        rst_e = 1'b0;
    logic        en_e  = 1'b0;
    logic        ld_e  = 1'b0;
    logic [31:0] cfg_e = '0;
    always @(posedge clk) begin
        rst_e <= rst_n;
        en_e  <= chip_en;
        ld_e  <= cfg_load;
        cfg_e <= cfg_offset;
    end

    // Reference model built from the requirements
    int m_chip = LAST;
    int m_fn   = 4095;
    int m_act  [4] = '{0, 0, 0, 0};
    int m_pend [4] = '{0, 0, 0, 0};
    bit m_arm  = 1'b0;
    int mis_r2 = 0, mis_r3 = 0, mis_r7 = 0, mis_r8 = 0;
    int mis_r9 = 0, mis_r10 = 0, mis_r11 = 0, mis_r12 = 0;
    int seen_cnt [4];
    int seen_pos [4];
    int page_cnt = 0, page_pos = -1;

    function automatic int clampu(input int v, input int ch);
        if (ch == 0)  return 0;     // R5 broadcast channel
        if (v > 149)  return 149;   // R4 limit
        return v;
    endfunction

    task automatic clear_seen();
        for (int i = 0; i < 4; i++) begin
            seen_cnt[i] = 0;
            seen_pos[i] = -1;
        end
        page_cnt = 0;
        page_pos = -1;
    endtask

    always @(negedge clk) begin
        if (!rst_e) begin
            m_chip = LAST;
            m_fn   = 4095;
            m_arm  = 1'b0;
            for (int i = 0; i < 4; i++) m_act[i] = 0;
        end else begin
            int  gpos;
            int  ppos;
            bit  e;
            if (en_e) begin
                if (m_chip == LAST) begin
                    m_chip = 0;
                    m_fn   = (m_fn + 1) % 4096;
                    if (m_arm) begin
                        for (int i = 0; i < 4; i++) m_act[i] = m_pend[i];
                        m_arm = 1'b0;
                    end
                end else begin
                    m_chip = m_chip + 1;
                end
            end
            if (ld_e) begin
                for (int i = 0; i < 4; i++) m_pend[i] = clampu(int'(cfg_e[i*8 +: 8]), i);
                m_arm = 1'b1;
            end
            if (chip_pos !== 16'(m_chip) || frame_num !== 12'(m_fn)) mis_r2++;
            for (int i = 0; i < 4; i++) begin
                e = en_e && (m_chip == m_act[i] * 256);
                if (chan_start[i] !== e) mis_r3++;
                if (chan_start[i] === 1'b1) begin
                    seen_cnt[i]++;
                    seen_pos[i] = int'(chip_pos);
                end
            end
            ppos = (m_act[1] * 256 + 30720) % 38400;
            if (page_start !== (en_e && m_chip == ppos)) mis_r7++;
            if (page_start === 1'b1) begin
                page_cnt++;
                page_pos = int'(chip_pos);
            end
            gpos = (m_fn % 2) * 38400 + m_chip;
            if (slot_start !== (en_e && (gpos % 5120 == 0)) || slot_num !== 4'(gpos / 5120)) mis_r8++;
            if (sub_start !== (en_e && (m_chip % 7680 == 0)) || sub_num !== 3'(m_chip / 7680)) mis_r9++;
            if (data_start !== (en_e && (m_chip % 7680 == 5120))) mis_r10++;
            if (ctrl_start !== (en_e && m_chip == 5120)) mis_r11++;
            if (frame_start !== (en_e && m_chip == 0)) mis_r2++;
            if (!en_e && (frame_start || (|chan_start) || page_start || ctrl_start ||
                          slot_start || sub_start || data_start)) mis_r12++;
        end
    end

    task automatic wait_pos(input int fn, input int chip);
        while (!(m_fn == fn && m_chip == chip)) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic t_reset();
        check(!frame_start && chan_start == 4'b0 && !page_start && !ctrl_start &&
              !slot_start && !sub_start && !data_start, "R1", "strobes in reset", 1, 0);
        check(chip_pos == 16'd38399, "R1", "chip_pos in reset", int'(chip_pos), 38399);
        check(frame_num == 12'd4095, "R1", "frame_num in reset", int'(frame_num), 4095);
        check(slot_num == 4'd14, "R1", "slot_num in reset", int'(slot_num), 14);
        check(sub_num == 3'd4, "R1", "sub_num in reset", int'(sub_num), 4);
    endtask

    task automatic t_first_tick();
        cfg_offset = {8'd3, 8'd200, 8'd149, 8'd77};
        cfg_load   = 1'b1;
        @(negedge clk); #1;
        cfg_load   = 1'b0;
        check(chip_pos == 16'd38399, "R2", "hold without chip_en", int'(chip_pos), 38399);
        check(!frame_start && !slot_start, "R12", "no strobe without tick", int'(frame_start), 0);
        clear_seen();
        chip_en = 1'b1;
        @(negedge clk); #1;
        check(frame_start && chip_pos == 16'd0, "R1", "first tick opens chip 0", int'(chip_pos), 0);
        check(frame_num == 12'd0, "R2", "frame number wraps 4095->0", int'(frame_num), 0);
        check(chan_start == 4'b0001, "R5", "only broadcast channel at chip 0", int'(chan_start), 1);
        check(slot_start && slot_num == 4'd0, "R8", "slot 0 at even frame", int'(slot_num), 0);
        check(sub_start && sub_num == 3'd0, "R9", "subframe 0 at frame start", int'(sub_num), 0);
    endtask

    task automatic t_frame0();
        wait_pos(0, 1000);
        chip_en = 1'b0;
        @(negedge clk); #1;
        check(!frame_start && chan_start == 4'b0 && !slot_start && !sub_start,
              "R12", "strobes low after idle edge", int'(chan_start), 0);
        repeat (4) @(negedge clk);
        #1;
        check(chip_pos == 16'd1000, "R2", "chip_pos held while idle", int'(chip_pos), 1000);
        chip_en = 1'b1;
        wait_pos(0, LAST);
        check(seen_cnt[0] == 1 && seen_pos[0] == 0, "R5", "broadcast ignores 77", seen_pos[0], 0);
        check(seen_cnt[1] == 1 && seen_pos[1] == 38144, "R3", "ch1 at 149 units", seen_pos[1], 38144);
        check(seen_cnt[2] == 1 && seen_pos[2] == 38144, "R4", "ch2 200 clamps to 149", seen_pos[2], 38144);
        check(seen_cnt[3] == 1 && seen_pos[3] == 768, "R3", "ch3 at 3 units", seen_pos[3], 768);
        check(page_cnt == 1 && page_pos == 30464, "R7", "paging lead in same frame", page_pos, 30464);
    endtask

    task automatic t_frame1();
        clear_seen();
        wait_pos(1, 20000);
        cfg_offset = {8'd100, 8'd149, 8'd10, 8'd5};
        cfg_load   = 1'b1;
        @(negedge clk); #1;
        cfg_load   = 1'b0;
        wait_pos(1, LAST);
        check(seen_cnt[1] == 1 && seen_pos[1] == 38144, "R6", "ch1 keeps old grid", seen_pos[1], 38144);
        check(seen_cnt[3] == 1 && seen_pos[3] == 768, "R6", "ch3 keeps old grid", seen_pos[3], 768);
        check(page_cnt == 1 && page_pos == 30464, "R7", "paging still on old grid", page_pos, 30464);
        check(slot_num == 4'd14, "R8", "last slot of odd frame", int'(slot_num), 14);
        clear_seen();
        wait_pos(2, 0);
        check(slot_start && slot_num == 4'd0, "R8", "slot index wraps at frame 2", int'(slot_num), 0);
        check(chan_start[0] && frame_start, "R5", "broadcast ignores 5", int'(chan_start[0]), 1);
    endtask

    task automatic t_frame2();
        wait_pos(2, LAST);
        check(seen_cnt[1] == 1 && seen_pos[1] == 2560, "R6", "ch1 new grid at 10 units", seen_pos[1], 2560);
        check(seen_cnt[3] == 1 && seen_pos[3] == 25600, "R3", "ch3 new grid at 100 units", seen_pos[3], 25600);
        check(seen_cnt[2] == 1 && seen_pos[2] == 38144, "R4", "ch2 stays clamped", seen_pos[2], 38144);
        check(page_cnt == 1 && page_pos == 33280, "R7", "paging wraps into previous frame", page_pos, 33280);
    endtask

    task automatic t_sweep();
        check(mis_r2 == 0, "R2", "counter/frame mismatch cycles", mis_r2, 0);
        check(mis_r3 == 0, "R3", "channel strobe mismatch cycles", mis_r3, 0);
        check(mis_r7 == 0, "R7", "paging strobe mismatch cycles", mis_r7, 0);
        check(mis_r8 == 0, "R8", "slot mismatch cycles", mis_r8, 0);
        check(mis_r9 == 0, "R9", "subframe mismatch cycles", mis_r9, 0);
        check(mis_r10 == 0, "R10", "data subframe mismatch cycles", mis_r10, 0);
        check(mis_r11 == 0, "R11", "control frame mismatch cycles", mis_r11, 0);
        check(mis_r12 == 0, "R12", "strobes without tick", mis_r12, 0);
    endtask

    initial begin
        rst_n      = 1'b0;
        chip_en    = 1'b0;
        cfg_load   = 1'b0;
        cfg_offset = '0;
        repeat (4) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_first_tick();
        t_frame0();
        t_frame1();
        t_frame2();
        t_sweep();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", 180000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule